// File: doc/BRIEF.md
# Key-Armed Watchdog with Reset-Out Pulse

This block guards a small 8-bit controller against runaway software. It stays disarmed after any reset. Software arms it by writing a two-byte key to a write-only service register on a plain register-write bus. Once armed, a counter advances on each machine-cycle enable. Writing the same key again restarts the count. Software has no way to read the counter, write it, or disarm the block.

If software stops servicing it, the counter overflows. The block then raises a one-cycle internal reset request. It also drives a reset-out pin high for a fixed number of oscillator clocks, unless a configuration bit leaves the pin undriven. Counting pauses in power-down. After a power-down that ends through the wake interrupt, counting stays paused until that interrupt line goes high again. A second configuration bit selects whether idle mode pauses the count.

Top module: `keyed_watchdog`

## Requirements
- R1: After the synchronous reset `rst`, the watchdog is disarmed, its counter holds zero, and neither `wdt_rst` nor `rst_out` is asserted.
- R2: A write of 0x1E followed directly by a write of 0xE1, both to address 0xA6, arms the watchdog with the count at zero. The same pair while already armed sets the count back to zero.
- R3: While armed, the counter steps by one in each clock cycle where `mc_tick` is high, and holds when it is low. The tick that brings it to all ones (2^CNT_W - 1 ticks after arming, 0x3FFF by default) is an overflow. `wdt_rst` is high for exactly the one cycle after the overflowing edge.
- R4: No bus write disarms an armed watchdog. Only `rst` or an overflow disarms it, and after an overflow no further `wdt_rst` follows until the key is written again.
- R5: If `cfg_no_rst_out` is 1 when an overflow starts a pulse, `rst_out` stays 0 for that whole pulse.
- R6: Otherwise, `rst_out` goes high in the cycle after `wdt_rst` and stays high for exactly PULSE_LEN clock cycles (98 by default). Oscillator clocks are counted here, not machine cycles.
- R7: A write of 0xE1 to 0xA6 that does not directly follow a 0x1E write to 0xA6 has no effect. Any other value written to 0xA6 after 0x1E cancels the first half of the key.
- R8: With `cfg_idle_halt` at 0 the counter keeps stepping while `idle` is high. With it at 1 the counter holds during `idle` and resumes when `idle` falls.
- R9: The counter holds while `pdown` is high. After `pdown` falls with `wake_n` low, it keeps holding until `wake_n` goes high.
- R10: An overflow while a reset-out pulse is running still produces the `wdt_rst` cycle. It neither restarts nor lengthens the running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| mc_tick | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| wr_en | input | 1 | Register-bus write strobe |
| wr_addr | input | 8 | Register-bus write address |
| wr_data | input | 8 | Register-bus write data |
| idle | input | 1 | Controller is in idle mode |
| pdown | input | 1 | Controller is in power-down mode |
| wake_n | input | 1 | Level of the active-low wake interrupt line |
| cfg_idle_halt | input | 1 | 1: hold the count during idle |
| cfg_no_rst_out | input | 1 | 1: leave the reset-out pin undriven on overflow |
| wdt_rst | output | 1 | One-cycle internal reset request on overflow |
| rst_out | output | 1 | Reset-out pin drive, high during the pulse |

## Verification
Arming takes effect at the edge that samples the second key write. With an unbroken tick, the overflow lands 2^CNT_W - 1 edges later, and `wdt_rst` is seen in the cycle after that edge. `rst_out` follows one cycle later and lasts PULSE_LEN cycles. Each gap of idle, power-down, held wake line or low tick pushes the overflow back by exactly its length in cycles. The driver turns every stimulus into an absolute expected cycle number and queues it. The monitor samples on the falling clock edge and compares each `wdt_rst` and each cycle of `rst_out` against the head of the queue. Any early, late, missing or extra event is therefore reported.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;

    // Default service address and the two halves of the unlock key.
    localparam logic [7:0] SVC_ADDR_DEF   = 8'hA6;
    localparam logic [7:0] KEY_FIRST_DEF  = 8'h1E;
    localparam logic [7:0] KEY_SECOND_DEF = 8'hE1;

    // Progress through the two-write unlock key.
    typedef enum logic {
        KS_WAIT = 1'b0,
        KS_HALF = 1'b1
    } wdk_kstate_e;

    // Mode configuration carried into the block as one bundle.
    typedef struct packed {
        logic idle_halt;
        logic no_rst_out;
    } wdk_cfg_t;

    // Low-power and wake status as seen by the counter gate.
    typedef struct packed {
        logic idle;
        logic pdown;
        logic wake_n;
    } wdk_pwr_t;

    // True when the counter must not advance in this cycle.
    function automatic logic wdk_blocked(input wdk_pwr_t pwr,
                                         input logic     wake_held,
                                         input wdk_cfg_t cfg);
        logic stalled_pd;
        logic stalled_idle;
        stalled_pd   = pwr.pdown | (wake_held & ~pwr.wake_n);
        stalled_idle = pwr.idle & cfg.idle_halt;
        return stalled_pd | stalled_idle;
    endfunction

endpackage

// File: rtl/wdk_key_decode.sv
`timescale 1ns/1ps
module wdk_key_decode
    import wdk_pkg::*;
#(
    parameter int                  ADDR_W     = 8,
    parameter int                  DATA_W     = 8,
    parameter logic [ADDR_W-1:0]   SVC_ADDR   = SVC_ADDR_DEF,
    parameter logic [DATA_W-1:0]   KEY_FIRST  = KEY_FIRST_DEF,
    parameter logic [DATA_W-1:0]   KEY_SECOND = KEY_SECOND_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_fire
);

    wdk_kstate_e state_q;
    logic        svc_hit;

    assign svc_hit  = wr_en && (wr_addr == SVC_ADDR);
    // The second half completes the key only straight after the first half.
    assign key_fire = svc_hit && (wr_data == KEY_SECOND) && (state_q == KS_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_WAIT;
        end else if (svc_hit) begin
            // Any service write other than the first half clears progress.
            state_q <= (wr_data == KEY_FIRST) ? KS_HALF : KS_WAIT;
        end
    end

endmodule

// File: rtl/wdk_gate.sv
`timescale 1ns/1ps
module wdk_gate
    import wdk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mc_tick,
    input  wdk_pwr_t pwr,
    input  wdk_cfg_t cfg,
    output logic     tick_ok,
    output logic     wake_hold
);

    // Remembers a power-down until the wake line has returned high.
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_hold <= 1'b0;
        end else begin
            wake_hold <= pwr.pdown | (wake_hold & ~pwr.wake_n);
        end
    end

    assign tick_ok = mc_tick & ~wdk_blocked(pwr, wake_hold, cfg);

endmodule

// File: rtl/wdk_counter.sv
`timescale 1ns/1ps
module wdk_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_fire,
    input  logic             tick_ok,
    output logic             armed,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (key_fire) begin
                // Arming and servicing both start from zero.
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed && tick_ok) begin
                if (cnt == LAST) begin
                    // Reaching all ones is the overflow: request reset, disarm.
                    ovf   <= 1'b1;
                    armed <= 1'b0;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + ONE;
                end
            end
        end
    end

endmodule

// File: rtl/wdk_pulse.sv
`timescale 1ns/1ps
module wdk_pulse #(
    parameter int PULSE_LEN = 98,
    parameter int PW        = $clog2(PULSE_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic          no_drive,
    output logic          busy,
    output logic [PW-1:0] pcnt,
    output logic          pin_drive
);

    localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            pcnt    <= '0;
            drive_q <= 1'b0;
        end else if (busy) begin
            // A trigger during a running pulse is ignored.
            if (pcnt == '0) begin
                busy <= 1'b0;
            end else begin
                pcnt <= pcnt - ONE;
            end
        end else if (trig) begin
            busy    <= 1'b1;
            pcnt    <= LOAD;
            drive_q <= ~no_drive;
        end
    end

    assign pin_drive = busy & drive_q;

endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
    import wdk_pkg::*;
#(
    parameter int                CNT_W      = 14,
    parameter int                PULSE_LEN  = 98,
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR   = SVC_ADDR_DEF,
    parameter logic [DATA_W-1:0] KEY_FIRST  = KEY_FIRST_DEF,
    parameter logic [DATA_W-1:0] KEY_SECOND = KEY_SECOND_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    input  logic              pdown,
    input  logic              wake_n,
    input  logic              cfg_idle_halt,
    input  logic              cfg_no_rst_out,
    output logic              wdt_rst,
    output logic              rst_out
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    wdk_cfg_t         cfg;
    wdk_pwr_t         pwr;
    logic             key_fire;
    logic             tick_ok;
    logic             wake_hold;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             pulse_busy;
    logic [PW-1:0]    pcnt;

    assign cfg = '{idle_halt: cfg_idle_halt, no_rst_out: cfg_no_rst_out};
    assign pwr = '{idle: idle, pdown: pdown, wake_n: wake_n};

    wdk_key_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR),
        .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .key_fire(key_fire)
    );

    wdk_gate u_gate (
        .clk(clk), .rst(rst), .mc_tick(mc_tick), .pwr(pwr), .cfg(cfg),
        .tick_ok(tick_ok), .wake_hold(wake_hold)
    );

    wdk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .key_fire(key_fire), .tick_ok(tick_ok),
        .armed(armed), .cnt(cnt), .ovf(wdt_rst)
    );

    wdk_pulse #(.PULSE_LEN(PULSE_LEN), .PW(PW)) u_pulse (
        .clk(clk), .rst(rst), .trig(wdt_rst), .no_drive(cfg.no_rst_out),
        .busy(pulse_busy), .pcnt(pcnt), .pin_drive(rst_out)
    );

endmodule

// File: rtl/wdk_checker.sv
`timescale 1ns/1ps
module wdk_checker #(
    parameter int CNT_W = 14,
    parameter int PW    = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             idle,
    input logic             pdown,
    input logic             wake_n,
    input logic             cfg_idle_halt,
    input logic             cfg_no_rst_out,
    input logic             wdt_rst,
    input logic             rst_out,
    input logic             armed,
    input logic [CNT_W-1:0] cnt,
    input logic             tick_ok,
    input logic             key_fire,
    input logic             wake_hold,
    input logic             pulse_busy,
    input logic [PW-1:0]    pcnt
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam logic [PW-1:0]    PONE = PW'(1);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!armed && cnt == '0 && !wdt_rst && !rst_out));

    a_r1_disarmed_zero: assert property (@(posedge clk) disable iff (rst)
        !armed |-> cnt == '0);

    a_r2_key_arms: assert property (@(posedge clk) disable iff (rst)
        key_fire |=> (armed && cnt == '0));

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (armed && tick_ok && !key_fire && cnt != LAST) |=> cnt == $past(cnt) + ONE);

    a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    a_r4_stay_armed: assert property (@(posedge clk) disable iff (rst)
        armed |=> (armed || wdt_rst));

    a_r5_pin_quiet: assert property (@(posedge clk) disable iff (rst)
        (wdt_rst && !pulse_busy && cfg_no_rst_out) |=> !rst_out);

    a_r6_pin_starts: assert property (@(posedge clk) disable iff (rst)
        (wdt_rst && !pulse_busy && !cfg_no_rst_out) |=> rst_out);

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (idle && cfg_idle_halt && !key_fire) |=> $stable(cnt));

    a_r9_pdown_hold: assert property (@(posedge clk) disable iff (rst)
        ((pdown || (wake_hold && !wake_n)) && !key_fire) |=> $stable(cnt));

    a_r10_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (wdt_rst && pulse_busy && pcnt != '0) |=> (pulse_busy && pcnt == $past(pcnt) - PONE));

endmodule

bind keyed_watchdog wdk_checker #(.CNT_W(CNT_W), .PW(PW)) u_chk (
    .clk(clk), .rst(rst), .idle(idle), .pdown(pdown), .wake_n(wake_n),
    .cfg_idle_halt(cfg_idle_halt), .cfg_no_rst_out(cfg_no_rst_out),
    .wdt_rst(wdt_rst), .rst_out(rst_out), .armed(armed), .cnt(cnt),
    .tick_ok(tick_ok), .key_fire(key_fire), .wake_hold(wake_hold),
    .pulse_busy(pulse_busy), .pcnt(pcnt)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;

    localparam int CW  = 6;
    localparam int PL  = 98;
    localparam int OVF = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mc_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       idle = 1'b0;
    logic       pdown = 1'b0;
    logic       wake_n = 1'b1;
    logic       cfg_idle_halt = 1'b0;
    logic       cfg_no_rst_out = 1'b0;
    logic       wdt_rst;
    logic       rst_out;

    always #2.5 clk = ~clk;

    keyed_watchdog #(.CNT_W(CW), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst(rst), .mc_tick(mc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .idle(idle), .pdown(pdown),
        .wake_n(wake_n), .cfg_idle_halt(cfg_idle_halt),
        .cfg_no_rst_out(cfg_no_rst_out), .wdt_rst(wdt_rst), .rst_out(rst_out)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int at; string req; } ev_t;
    typedef struct { int at; bit drive; string req; } pl_t;

    ev_t   q_rst[$];
    pl_t   q_pl[$];
    int    checks = 0;
    int    errors = 0;
    string quiet_req = "R1";
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    bit    p_live = 1'b0;
    bit    p_drive = 1'b0;
    int    p_end = 0;
    string p_req = "R6";

    task automatic fail(input string req, input string what, input int act, input int exp);
        checks++;
        errors++;
        $display("FAIL %s: %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    endtask

    // Monitor: pops expected events as the design produces them.
    always @(negedge clk) begin
        if (mon_on) begin
            if (wdt_rst) begin
                if (q_rst.size() > 0 && q_rst[0].at == cyc) begin
                    checks++;
                    void'(q_rst.pop_front());
                end else begin
                    fail(quiet_req, "unexpected wdt_rst", 1, 0);
                end
            end else if (q_rst.size() > 0 && q_rst[0].at <= cyc) begin
                fail(q_rst[0].req, "wdt_rst missing at expected cycle", 0, 1);
                void'(q_rst.pop_front());
            end
            if (q_pl.size() > 0 && q_pl[0].at == cyc) begin
                p_live  = 1'b1;
                p_drive = q_pl[0].drive;
                p_req   = q_pl[0].req;
                p_end   = cyc + PL - 1;
                void'(q_pl.pop_front());
            end
            if (rst_out !== (p_live && p_drive)) begin
                fail(p_live ? p_req : "R6", "rst_out level", int'(rst_out), int'(p_live && p_drive));
            end
            if (p_live && cyc == p_end) begin
                checks++;
                p_live = 1'b0;
            end
        end
    end

    // Driver helpers; each is entered and left at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    endtask

    task automatic key_pair(output int armed_at);
        wr(8'hA6, 8'h1E);
        armed_at = cyc + 1;
        wr(8'hA6, 8'hE1);
    endtask

    task automatic expect_ovf(input int at, input bit with_pulse, input bit drive, input string req);
        q_rst.push_back('{at: at, req: req});
        if (with_pulse) q_pl.push_back('{at: at + 1, drive: drive, req: req});
    endtask

    task automatic drain();
        while (q_rst.size() > 0 || q_pl.size() > 0 || p_live) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req);
        int e0;
        e0 = errors;
        quiet_req = req;
        repeat (n) @(negedge clk);
        if (errors == e0) checks++;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        int a;
        int b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: outputs quiet out of reset, and nothing fires unarmed.
        if (wdt_rst !== 1'b0) fail("R1", "wdt_rst after reset", int'(wdt_rst), 0); else checks++;
        if (rst_out !== 1'b0) fail("R1", "rst_out after reset", int'(rst_out), 0); else checks++;
        mon_on = 1'b1;
        quiet(150, "R1");

        // R7: lone second half, and a broken key, must not arm.
        wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'h55);
        wr(8'hA6, 8'hE1);
        quiet(150, "R7");

        // R2, R3, R6: plain arm, overflow, driven pulse.
        quiet_req = "R3";
        key_pair(a);
        expect_ovf(a + OVF, 1'b1, 1'b1, "R6");
        drain();

        // R2: servicing restarts the count.
        quiet_req = "R2";
        key_pair(a);
        repeat (40) @(negedge clk);
        key_pair(b);
        expect_ovf(b + OVF, 1'b1, 1'b1, "R2");
        drain();

        // R4: stray writes do not disarm; disarmed after overflow.
        quiet_req = "R4";
        key_pair(a);
        expect_ovf(a + OVF, 1'b1, 1'b1, "R4");
        wr(8'hA6, 8'h00);
        wr(8'hA6, 8'hFF);
        wr(8'h8E, 8'h18);
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'h77);
        drain();
        quiet(150, "R4");

        // R5: pin left undriven.
        quiet_req = "R5";
        cfg_no_rst_out = 1'b1;
        key_pair(a);
        expect_ovf(a + OVF, 1'b1, 1'b0, "R5");
        drain();
        cfg_no_rst_out = 1'b0;

        // R3: a low tick holds the count.
        quiet_req = "R3";
        key_pair(a);
        expect_ovf(a + OVF + 25, 1'b1, 1'b1, "R3");
        repeat (5) @(negedge clk);
        mc_tick = 1'b0;
        repeat (25) @(negedge clk);
        mc_tick = 1'b1;
        drain();

        // R8: idle keeps counting with halt off, holds with halt on.
        quiet_req = "R8";
        key_pair(a);
        expect_ovf(a + OVF, 1'b1, 1'b1, "R8");
        repeat (5) @(negedge clk);
        idle = 1'b1;
        repeat (20) @(negedge clk);
        idle = 1'b0;
        drain();
        cfg_idle_halt = 1'b1;
        key_pair(a);
        expect_ovf(a + OVF + 20, 1'b1, 1'b1, "R8");
        repeat (5) @(negedge clk);
        idle = 1'b1;
        repeat (20) @(negedge clk);
        idle = 1'b0;
        drain();
        cfg_idle_halt = 1'b0;

        // R9: power-down, then a wake line still low, both hold.
        quiet_req = "R9";
        key_pair(a);
        expect_ovf(a + OVF + 30, 1'b1, 1'b1, "R9");
        repeat (5) @(negedge clk);
        pdown = 1'b1;
        repeat (20) @(negedge clk);
        pdown = 1'b0;
        wake_n = 1'b0;
        repeat (10) @(negedge clk);
        wake_n = 1'b1;
        drain();
        key_pair(a);
        expect_ovf(a + OVF + 15, 1'b1, 1'b1, "R9");
        repeat (5) @(negedge clk);
        pdown = 1'b1;
        repeat (15) @(negedge clk);
        pdown = 1'b0;
        drain();

        // R10: second overflow inside a running pulse.
        quiet_req = "R10";
        key_pair(a);
        expect_ovf(a + OVF, 1'b1, 1'b1, "R6");
        wait_until(a + OVF);
        key_pair(b);
        expect_ovf(b + OVF, 1'b0, 1'b0, "R10");
        drain();
        quiet(150, "R4");

        done = 1'b1;
        mon_on = 1'b0;
        while (q_rst.size() > 0) begin
            fail(q_rst[0].req, "expected wdt_rst never seen", 0, 1);
            void'(q_rst.pop_front());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, 60000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule